// File: doc/BRIEF.md
# Selectable-ratio half-band decimation chain

This block reduces the rate of a signed sample stream from an oversampling converter front end. Three half-band FIR decimators are chained, and each one halves the rate. A two-bit mode input selects where the output is taken from: the raw input stream, or the output of the first, second or third stage. The overall ratio is therefore 1, 2, 4 or 8. A single-cycle strobe marks each word at the chosen rate. For example, a 20 MHz input becomes 10, 5 or 2.5 MHz at the output.

Each stage keeps a delay line that shifts only when an input sample arrives. It computes one result for every second sample. Each symmetric coefficient pair multiplies the sum of its two samples, and the zero taps of the half-band response are never formed. The centre tap is a plain shift. Every stage rounds its accumulator back to 16 bits and clamps it to the 16-bit range, so later stages and the output never see a wrapped value. All three stages run all the time, and the mode only steers the output multiplexer.

Top module: `hbdec_chain`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no input, `valid_o` is 0 and `data_o` is 0.
- R2: `mode_i` selects the ratio: 0 means 1x, 1 means 2x, 2 means 4x and 3 means 8x. In 1x mode, each input word appears one clock after its `valid_i` as `data_o = {data_i, 4'b0000}`, with `valid_o` high for that one cycle.
- R3: Every stage fires on the 2nd, 4th, 6th and later samples it accepts after reset. A stage's result m is sum over k of h[k]·x[2m+1−k], where x before the first sample counts as zero. Stage 1 has 23 taps. With d the distance from the centre tap, its coefficients are h(0)=16384, h(±1)=9900, h(±3)=−2400, h(±5)=1000, h(±7)=−400, h(±9)=130 and h(±11)=−38. Every other tap is zero. Mode 1 outputs the stage 1 results.
- R4: Stage 2 has 43 taps and feeds on the stage 1 results. Its coefficients are h(0)=16384, and for d = ±1, ±3, …, ±21 they are 10360, −3300, 1800, −1100, 700, −430, 250, −135, 65, −28 and 10. Every other tap is zero. Mode 2 outputs the stage 2 results.
- R5: Stage 3 has 47 taps and feeds on the stage 2 results. Its coefficients are h(0)=16384, and for d = ±1, ±3, …, ±23 they are 10380, −3330, 1850, −1150, 720, −450, 270, −160, 90, −48, 22 and −2. Every other tap is zero. Mode 3 outputs the stage 3 results.
- R6: Stage 1 receives `data_i` multiplied by 16, in two's complement. Coefficients are scaled by 2^15, and the sum of all taps in every stage is exactly 32768, so a settled constant input passes through at unity gain.
- R7: Each stage's result is floor((acc + 2^14) / 2^15), which rounds to nearest with ties going up.
- R8: A result above 32767 becomes 32767, and a result below −32768 becomes −32768. This applies in every stage.
- R9: `data_o` keeps its last word in every cycle where `valid_o` is low.
- R10: Cycles with `valid_i` low change nothing. A stream with idle gaps yields the same words as the same stream without gaps.
- R11: In modes 1 to 3, with the mode held constant, `valid_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Ratio select: 0=1x, 1=2x, 2=4x, 3=8x |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | 12 | Input sample, two's complement |
| valid_o | output | 1 | Output word strobe |
| data_o | output | 16 | Output word, two's complement |

## Verification
The bench sends an impulse on each of the two input phases. A stage that decimated on the wrong phase, or used the wrong coefficient at some distance, would give a different impulse response. On the second phase a stage that formed a product for a zero tap would give a non-zero result. The bench also sends a full-scale sign pattern matched to the stage 1 taps. A stage that wrapped instead of clamping would flip the sign of that result. A stream of tiny values puts the rounding into the half-LSB region, where truncation or round-half-to-even shows up as an off-by-one. A full-scale stream with idle gaps, checked against the gapless model, catches a delay line or phase that moves on idle cycles.

// File: rtl/hbdec_pkg.sv
package hbdec_pkg;
  localparam int NSTG  = 3;
  localparam int CFRAC = 15;   // coefficient scale 2^CFRAC, centre tap = 2^(CFRAC-1)
  localparam int CW    = 16;

  // number of distinct non-zero side coefficients per stage
  function automatic int ncoef(input int stg);
    case (stg)
      0:       return 6;
      1:       return 11;
      default: return 12;
    endcase
  endfunction

  // side coefficient at distance 2*j+1 from the centre
  function automatic int coef(input int stg, input int j);
    int c;
    c = 0;
    case (stg)
      0: case (j)
           0: c = 9900;  1: c = -2400; 2: c = 1000; 3: c = -400;
           4: c = 130;   5: c = -38;
           default: c = 0;
         endcase
      1: case (j)
           0: c = 10360; 1: c = -3300; 2: c = 1800; 3: c = -1100;
           4: c = 700;   5: c = -430;  6: c = 250;  7: c = -135;
           8: c = 65;    9: c = -28;   10: c = 10;
           default: c = 0;
         endcase
      default: case (j)
           0: c = 10380; 1: c = -3330; 2: c = 1850; 3: c = -1150;
           4: c = 720;   5: c = -450;  6: c = 270;  7: c = -160;
           8: c = 90;    9: c = -48;   10: c = 22;  11: c = -2;
           default: c = 0;
         endcase
    endcase
    return c;
  endfunction
endpackage

// File: rtl/hbdec_stage.sv
module hbdec_stage
  import hbdec_pkg::*;
#(
  parameter int STG = 0,
  parameter int DW  = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] data_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] data_o
);
  localparam int NC  = ncoef(STG);
  localparam int NT  = 4 * NC - 1;
  localparam int MID = 2 * NC - 1;
  localparam int AW  = DW + CW + 8;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (CFRAC - 1);
  localparam logic signed [AW-1:0] MAXV = AW'((1 << (DW - 1)) - 1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

  logic signed [DW-1:0] dl_q [NT];
  logic                 ph_q, fire_q;

  // delay line advances only on accepted samples
  for (genvar i = 0; i < NT; i++) begin : g_dl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      dl_q[i] <= '0;
      else if (valid_i) dl_q[i] <= (i == 0) ? data_i : dl_q[(i == 0) ? 0 : i - 1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= valid_i & ph_q;
      if (valid_i) ph_q <= ~ph_q;
    end
  end

  // folded sum over non-zero taps only; centre tap is a shift
  logic signed [AW-1:0] psum [NC+1];
  assign psum[0] = AW'(dl_q[MID]) <<< (CFRAC - 1);

  for (genvar j = 0; j < NC; j++) begin : g_tap
    localparam int D = 2 * j + 1;
    localparam logic signed [CW-1:0] CJ = CW'(coef(STG, j));
    logic signed [DW:0] fold;
    assign fold = {dl_q[MID-D][DW-1], dl_q[MID-D]} + {dl_q[MID+D][DW-1], dl_q[MID+D]};
    assign psum[j+1] = psum[j] + AW'(fold) * AW'(CJ);
  end

  logic signed [AW-1:0] rnd;
  logic signed [DW-1:0] res;
  assign rnd = (psum[NC] + HALF) >>> CFRAC;

  always_comb begin
    if (rnd > MAXV)      res = MAXV[DW-1:0];
    else if (rnd < MINV) res = MINV[DW-1:0];
    else                 res = rnd[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= fire_q;
      if (fire_q) data_o <= res;
    end
  end
endmodule

// File: rtl/hbdec_tapsel.sv
module hbdec_tapsel
  import hbdec_pkg::*;
#(
  parameter int DW = 16,
  localparam int MW = $clog2(NSTG + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [MW-1:0]        sel_i,
  input  logic [NSTG:0]        tap_v_i,
  input  logic signed [DW-1:0] tap_d_i [NSTG+1],
  output logic                 valid_o,
  output logic signed [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= tap_v_i[sel_i];
      if (tap_v_i[sel_i]) data_o <= tap_d_i[sel_i];
    end
  end
endmodule

// File: rtl/hbdec_chain.sv
module hbdec_chain
  import hbdec_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o
);
  localparam int PAD = OUT_W - IN_W;

  logic [NSTG:0]           tv;
  logic signed [OUT_W-1:0] td [NSTG+1];
  logic signed [OUT_W-1:0] dout;

  assign tv[0] = valid_i;
  assign td[0] = {data_i, {PAD{1'b0}}};

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    hbdec_stage #(.STG(g), .DW(OUT_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (tv[g]),
      .data_i  (td[g]),
      .valid_o (tv[g+1]),
      .data_o  (td[g+1])
    );
  end

  hbdec_tapsel #(.DW(OUT_W)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (mode_i),
    .tap_v_i (tv),
    .tap_d_i (td),
    .valid_o (valid_o),
    .data_o  (dout)
  );

  assign data_o = dout;
endmodule

// File: rtl/hbdec_chain_chk.sv
module hbdec_chain_chk #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             valid_i,
  input logic [IN_W-1:0]  data_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] data_o
);
  a_r2_bypass_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 2'd0 |=> valid_o && data_o == {$past(data_i), {(OUT_W-IN_W){1'b0}}});

  a_r2_bypass_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && mode_i == 2'd0 |=> !valid_o);

  a_r9_hold_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  a_r11_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && mode_i != 2'd0 && $stable(mode_i) |=> !valid_o);
endmodule

bind hbdec_chain hbdec_chain_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/hbdec_chain_test.sv
module hbdec_chain_test;
  localparam int IN_W  = 12;
  localparam int OUT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       mode_i = 2'd0;
  logic             valid_i = 1'b0;
  logic [IN_W-1:0]  data_i = '0;
  logic             valid_o;
  logic [OUT_W-1:0] data_o;

  always #5 clk_i = ~clk_i;

  hbdec_chain #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (.*);

  typedef int iq_t[$];
  typedef struct { int val; string req; } exp_t;

  localparam int U1[6]  = '{9900, -2400, 1000, -400, 130, -38};
  localparam int U2[11] = '{10360, -3300, 1800, -1100, 700, -430, 250, -135, 65, -28, 10};
  localparam int U3[12] = '{10380, -3330, 1850, -1150, 720, -450, 270, -160, 90, -48, 22, -2};

  int    h1[23], h2[43], h3[47];
  exp_t  sb[$];
  exp_t  cur_e;
  string cur_req = "R1";
  int    n_tests = 0, n_fail = 0;
  bit    done = 0, b2b = 0, prev_v = 0;

  function automatic int tap(int s, int k);
    case (s)
      1:       return h1[k];
      2:       return h2[k];
      default: return h3[k];
    endcase
  endfunction

  function automatic iq_t filt(iq_t x, int s);
    iq_t y;
    int nt;
    longint acc, r;
    nt = (s == 1) ? 23 : (s == 2) ? 43 : 47;
    for (int m = 0; 2 * m + 1 < x.size(); m++) begin
      acc = 0;
      for (int k = 0; k < nt; k++)
        if (2 * m + 1 - k >= 0) acc += longint'(tap(s, k)) * longint'(x[2*m+1-k]);
      r = (acc + 16384) >>> 15;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      y.push_back(int'(r));
    end
    return y;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o && prev_v && mode_i != 2'd0) b2b = 1;
      prev_v = valid_o;
      if (valid_o) begin
        if (sb.size() == 0) check(cur_req, 1, 0, "unexpected output word");
        else begin
          cur_e = sb.pop_front();
          check(cur_e.req, int'($signed(data_o)), cur_e.val, "output word");
        end
      end
    end else prev_v = 0;
  end

  task automatic do_reset();
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // driver: computes expected words, queues them, then drives the stream
  task automatic run(input int md, input iq_t x, input int gaps, input string req);
    iq_t y;
    do_reset();
    mode_i  = md[1:0];
    cur_req = req;
    b2b     = 0;
    foreach (x[i]) y.push_back(x[i] * 16);
    for (int s = 1; s <= md; s++) y = filt(y, s);
    foreach (y[i]) sb.push_back('{y[i], req});
    foreach (x[i]) begin
      @(negedge clk_i);
      valid_i = 1'b1;
      data_i  = x[i][IN_W-1:0];
      if (gaps != 0 && (i % 3) == 1) begin
        @(negedge clk_i);
        valid_i = 1'b0;
      end
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (16) @(negedge clk_i);
    check(req, sb.size(), 0, "words still pending");
    sb.delete();
    if (y.size() > 0) check("R9", int'($signed(data_o)), y[y.size()-1], "held word");
    if (md != 0) check("R11", int'(b2b), 0, "consecutive valid_o");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    iq_t x;
    int  st;
    foreach (h1[k]) h1[k] = 0;
    foreach (h2[k]) h2[k] = 0;
    foreach (h3[k]) h3[k] = 0;
    h1[11] = 16384; h2[21] = 16384; h3[23] = 16384;
    for (int j = 0; j < 6; j++)  begin h1[11-2*j-1] = U1[j]; h1[11+2*j+1] = U1[j]; end
    for (int j = 0; j < 11; j++) begin h2[21-2*j-1] = U2[j]; h2[21+2*j+1] = U2[j]; end
    for (int j = 0; j < 12; j++) begin h3[23-2*j-1] = U3[j]; h3[23+2*j+1] = U3[j]; end

    // R1: reset state
    repeat (2) @(negedge clk_i);
    check("R1", int'(valid_o), 0, "valid_o in reset");
    check("R1", int'(data_o), 0, "data_o in reset");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1", int'(valid_o), 0, "valid_o idle after reset");
    check("R1", int'(data_o), 0, "data_o idle after reset");

    // R2: bypass with gaps, including extremes
    x = {};
    for (int i = 0; i < 30; i++) x.push_back(i * 137 - 2048);
    x.push_back(2047);
    x.push_back(-2048);
    run(0, x, 1, "R2");

    // R3: impulse on first phase and on second phase
    x = {};
    for (int i = 0; i < 60; i++) x.push_back(0);
    x[0] = 1000;
    run(1, x, 0, "R3");
    x = {};
    for (int i = 0; i < 60; i++) x.push_back(0);
    x[1] = -1500;
    run(1, x, 0, "R3");

    // R4, R5: impulse through deeper stages
    x = {};
    for (int i = 0; i < 220; i++) x.push_back(0);
    x[0] = 1800;
    run(2, x, 0, "R4");
    x = {};
    for (int i = 0; i < 440; i++) x.push_back(0);
    x[3] = -2000;
    run(3, x, 0, "R5");

    // R6: constant full-scale input settles at unity gain
    x = {};
    for (int i = 0; i < 440; i++) x.push_back(2047);
    run(3, x, 0, "R6");
    check("R6", int'($signed(data_o)), 2047 * 16, "settled unity-gain word");

    // R7: small values exercise rounding
    x = {};
    st = 7;
    for (int i = 0; i < 120; i++) begin
      st = st * 1103515245 + 12345;
      x.push_back(int'((st >>> 16) & 7) - 3);
    end
    run(1, x, 0, "R7");

    // R8: sign pattern matched to stage 1 taps, both polarities
    x = {};
    for (int i = 0; i < 40; i++) x.push_back(0);
    for (int k = 0; k < 23; k++) if (h1[k] != 0) x[31-k] = (h1[k] > 0) ? 2047 : -2047;
    run(1, x, 0, "R8");
    foreach (x[i]) x[i] = -x[i];
    run(1, x, 0, "R8");

    // R10: full-scale pseudo-random stream with idle gaps, 8x
    x = {};
    st = 99;
    for (int i = 0; i < 400; i++) begin
      st = st * 1103515245 + 12345;
      x.push_back(int'((st >>> 12) & 4095) - 2048);
    end
    run(3, x, 1, "R10");
    run(2, x, 1, "R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule